// File: doc/BRIEF.md
# Subtract-and-Branch One-Instruction Processor

This block is a small processor with a single kind of instruction. Each instruction occupies three consecutive words of an internal memory. The first two words give two operand addresses and the third word gives a branch target. The core subtracts the word at the first operand address from the word at the second operand address and stores the difference back at the second address. If the difference is negative, control moves to the target. Otherwise control moves on to the next three-word group. There is no opcode, so the datapath is a memory-to-memory subtractor with a conditional load of the program counter.

While reset is held, the program is written into the 256-word memory through a load port. When reset is released, execution starts at address 0 and proceeds one instruction every seven clock cycles. The program counter, the most recent difference and a halt flag are driven out as status, for example to light a row of LEDs. A taken branch to the all-ones address, or to the address of the instruction that branches, stops the machine.

Top module: `subleq_core`

## Requirements
- R1: While `rst` is high, `pc_o` reads 0, `result_o` reads 0 and `halted_o` reads 0.
- R2: A word on `load_data` is stored at `load_addr` on a rising edge when both `load_we` and `rst` are high. When `rst` is low, `load_we` has no effect on memory.
- R3: The instruction at program counter P takes its first operand address from word P, its second operand address from word P+1 and its target from word P+2, with all three addresses taken modulo 256. Word[B] is replaced by word[B] minus word[A], wrapping modulo 2^16.
- R4: Each instruction takes exactly 7 cycles. The new difference appears on `result_o` 6 cycles after the instruction starts. `pc_o` changes only at the 7th edge.
- R5: When the difference has bit 15 set, `pc_o` becomes the target C.
- R6: When the difference has bit 15 clear (zero included), `pc_o` becomes P+3 modulo 256.
- R7: A taken branch whose target is 255 or equal to P sets `halted_o`. `pc_o` still takes the target. After that, `pc_o`, `result_o`, `halted_o` and memory stay frozen until reset.
- R8: Only bits 7:0 of an operand or target word form the address. Bits 15:8 of those words are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; also enables program loading |
| load_we | input | 1 | Load strobe, honoured only during reset |
| load_addr | input | 8 | Memory address for loading |
| load_data | input | 16 | Word to load |
| pc_o | output | 8 | Program counter |
| result_o | output | 16 | Most recent difference written back |
| halted_o | output | 1 | Machine has stopped |

## Verification
The bench checks several corner cases. A difference of exactly zero must fall through; a core that branches on less-or-equal would jump instead. Subtracting 1 from 0x8000 gives a positive 0x7FFF; a core that uses a wider comparison or a signed-overflow rule would branch there. An instruction that straddles address 255 must wrap its operand fetches and its fall-through; a core that does not wrap would read or write the wrong words. Junk in the upper byte of the address fields must not move any access. Writes strobed on the load port while the core is running must be ignored; a core that honours them would corrupt the random programs and diverge from the model. Halting is checked on both the all-ones target and the self-jump, and the state must stay frozen afterwards; a core that kept running would change `pc_o` or `result_o`.

// File: rtl/subleq_pkg.sv
package subleq_pkg;

    localparam int WORD_W    = 16;
    localparam int ADDR_W    = 8;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int INSTR_LEN = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        ST_FETCH_A,
        ST_FETCH_B,
        ST_FETCH_C,
        ST_READ_A,
        ST_READ_B,
        ST_WRITE_B,
        ST_UPDATE,
        ST_HALT
    } phase_t;

    typedef struct packed {
        addr_t a;
        addr_t b;
        addr_t c;
    } operands_t;

    function automatic addr_t field_addr(word_t w);
        return w[ADDR_W-1:0];
    endfunction

    function automatic logic is_negative(word_t w);
        return w[WORD_W-1];
    endfunction

    function automatic addr_t addr_step(addr_t base, int unsigned k);
        return base + addr_t'(k);
    endfunction

endpackage

// File: rtl/subleq_mem.sv
module subleq_mem
    import subleq_pkg::*;
(
    input  logic  clk,
    input  logic  we,
    input  addr_t waddr,
    input  word_t wdata,
    input  addr_t raddr,
    output word_t rdata
);

    word_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/subleq_exec.sv
module subleq_exec
    import subleq_pkg::*;
(
    input  addr_t pc,
    input  addr_t target,
    input  word_t val_a,
    input  word_t val_b,
    input  word_t last_diff,
    output word_t diff,
    output addr_t next_pc,
    output logic  stop_hit
);

    logic taken;

    always_comb begin
        diff     = val_b - val_a;
        taken    = is_negative(last_diff);
        next_pc  = taken ? target : addr_step(pc, INSTR_LEN);
        stop_hit = taken && ((target == '1) || (target == pc));
    end

endmodule

// File: rtl/subleq_ctrl.sv
module subleq_ctrl
    import subleq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  word_t     rd_data,
    output addr_t     rd_addr,
    output logic      wr_en,
    output addr_t     wr_addr,
    output word_t     wr_data,
    input  word_t     diff,
    input  addr_t     next_pc,
    input  logic      stop_hit,
    output phase_t    phase,
    output addr_t     pc,
    output operands_t ops,
    output word_t     val_a,
    output word_t     val_b,
    output word_t     last_diff,
    output logic      halted
);

    always_comb begin
        case (phase)
            ST_FETCH_A: rd_addr = pc;
            ST_FETCH_B: rd_addr = addr_step(pc, 1);
            ST_FETCH_C: rd_addr = addr_step(pc, 2);
            ST_READ_A:  rd_addr = ops.a;
            default:    rd_addr = ops.b;
        endcase
        wr_en   = (phase == ST_WRITE_B);
        wr_addr = ops.b;
        wr_data = diff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= ST_FETCH_A;
            pc        <= '0;
            ops       <= '0;
            val_a     <= '0;
            val_b     <= '0;
            last_diff <= '0;
            halted    <= 1'b0;
        end else begin
            case (phase)
                ST_FETCH_A: begin
                    ops.a <= field_addr(rd_data);
                    phase <= ST_FETCH_B;
                end
                ST_FETCH_B: begin
                    ops.b <= field_addr(rd_data);
                    phase <= ST_FETCH_C;
                end
                ST_FETCH_C: begin
                    ops.c <= field_addr(rd_data);
                    phase <= ST_READ_A;
                end
                ST_READ_A: begin
                    val_a <= rd_data;
                    phase <= ST_READ_B;
                end
                ST_READ_B: begin
                    val_b <= rd_data;
                    phase <= ST_WRITE_B;
                end
                ST_WRITE_B: begin
                    last_diff <= diff;
                    phase     <= ST_UPDATE;
                end
                ST_UPDATE: begin
                    pc <= next_pc;
                    if (stop_hit) begin
                        halted <= 1'b1;
                        phase  <= ST_HALT;
                    end else begin
                        phase  <= ST_FETCH_A;
                    end
                end
                default: phase <= ST_HALT;
            endcase
        end
    end

endmodule

// File: rtl/subleq_core.sv
module subleq_core
    import subleq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_we,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [WORD_W-1:0] load_data,
    output logic [ADDR_W-1:0] pc_o,
    output logic [WORD_W-1:0] result_o,
    output logic              halted_o
);

    word_t     rd_data;
    addr_t     rd_addr;
    logic      core_we;
    addr_t     core_waddr;
    word_t     core_wdata;
    word_t     diff;
    addr_t     next_pc;
    logic      stop_hit;
    phase_t    phase;
    addr_t     pc;
    operands_t ops;
    word_t     val_a;
    word_t     val_b;
    word_t     last_diff;
    logic      halted;
    logic      mem_we;
    addr_t     mem_waddr;
    word_t     mem_wdata;

    always_comb begin
        mem_we    = rst ? load_we   : core_we;
        mem_waddr = rst ? load_addr : core_waddr;
        mem_wdata = rst ? load_data : core_wdata;
    end

    subleq_mem u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    subleq_exec u_exec (
        .pc        (pc),
        .target    (ops.c),
        .val_a     (val_a),
        .val_b     (val_b),
        .last_diff (last_diff),
        .diff      (diff),
        .next_pc   (next_pc),
        .stop_hit  (stop_hit)
    );

    subleq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (core_we),
        .wr_addr   (core_waddr),
        .wr_data   (core_wdata),
        .diff      (diff),
        .next_pc   (next_pc),
        .stop_hit  (stop_hit),
        .phase     (phase),
        .pc        (pc),
        .ops       (ops),
        .val_a     (val_a),
        .val_b     (val_b),
        .last_diff (last_diff),
        .halted    (halted)
    );

    assign pc_o     = pc;
    assign result_o = last_diff;
    assign halted_o = halted;

endmodule

// File: rtl/subleq_checker.sv
module subleq_checker
    import subleq_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input addr_t  pc_o,
    input word_t  result_o,
    input logic   halted_o,
    input phase_t phase,
    input addr_t  target
);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && result_o == '0 && !halted_o)); // R1

    AST_PC_HOLDS_MID_INSTR: assert property (@(posedge clk) disable iff (rst)
        (phase != ST_UPDATE) |=> $stable(pc_o)); // R4

    AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_UPDATE && result_o[WORD_W-1]) |=> (pc_o == $past(target))); // R5

    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_UPDATE && !result_o[WORD_W-1])
            |=> (pc_o == addr_t'($past(pc_o) + addr_t'(INSTR_LEN)))); // R6

    AST_HALT_ON_NEGATIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(halted_o) |-> result_o[WORD_W-1]); // R7

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        halted_o |=> (halted_o && $stable(pc_o) && $stable(result_o))); // R7

endmodule

bind subleq_core subleq_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .pc_o     (pc_o),
    .result_o (result_o),
    .halted_o (halted_o),
    .phase    (phase),
    .target   (ops.c)
);

// File: tb/sim_subleq_core.sv
module sim_subleq_core;

    logic        clk;
    logic        rst;
    logic        load_we;
    logic [7:0]  load_addr;
    logic [15:0] load_data;
    logic [7:0]  pc_o;
    logic [15:0] result_o;
    logic        halted_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] prog [256];
    logic [15:0] m    [256];
    logic [7:0]  mpc;
    logic [15:0] mres;
    logic        mhalt;

    subleq_core u0 (
        .clk       (clk),
        .rst       (rst),
        .load_we   (load_we),
        .load_addr (load_addr),
        .load_data (load_data),
        .pc_o      (pc_o),
        .result_o  (result_o),
        .halted_o  (halted_o)
    );

    initial begin
        clk = 0;
        forever #10 clk = ~clk;
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic model_step();
        logic [7:0]  a, b, c;
        logic [15:0] d;
        if (mhalt) return;
        a = m[mpc][7:0];
        b = m[8'(mpc + 8'd1)][7:0];
        c = m[8'(mpc + 8'd2)][7:0];
        d = m[b] - m[a];
        m[b] = d;
        mres = d;
        if (d[15]) begin
            if (c == 8'hFF || c == mpc) mhalt = 1;
            mpc = c;
        end else begin
            mpc = 8'(mpc + 8'd3);
        end
    endtask

    task automatic load_and_start();
        rst = 1;
        load_we = 0;
        repeat (2) @(negedge clk);
        chk("R1 pc in reset", 32'(pc_o), 32'd0);
        chk("R1 result in reset", 32'(result_o), 32'd0);
        chk("R1 halted in reset", 32'(halted_o), 32'd0);
        for (int i = 0; i < 256; i++) begin
            load_we   = 1;
            load_addr = 8'(i);
            load_data = prog[i];
            @(negedge clk);
        end
        load_we = 0;
        for (int i = 0; i < 256; i++) m[i] = prog[i];
        mpc = 0;
        mres = 0;
        mhalt = 0;
        rst = 0;
    endtask

    task automatic run_steps(int n, bit poke);
        logic [7:0] old_pc;
        for (int s = 0; s < n; s++) begin
            old_pc = mpc;
            model_step();
            for (int k = 0; k < 6; k++) begin
                load_we   = poke;
                load_addr = 8'($urandom);
                load_data = 16'($urandom);
                @(negedge clk);
            end
            chk("R4 pc held before 7th edge", 32'(pc_o), 32'(old_pc));
            chk(poke ? "R2/R3 difference (load ignored)" : "R3 difference", 32'(result_o), 32'(mres));
            @(negedge clk);
            chk(mres[15] ? "R5 pc after branch" : "R6 pc after fall-through", 32'(pc_o), 32'(mpc));
            chk("R7 halted flag", 32'(halted_o), 32'(mhalt));
        end
        load_we = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5B1E0));
        rst = 1;
        load_we = 0;
        load_addr = 0;
        load_data = 0;

        // Directed: fall-through, zero result, all-ones halt, upper-byte junk (R8)
        for (int i = 0; i < 256; i++) prog[i] = 16'h0;
        prog[0] = 16'hAB0A; prog[1] = 16'h550B; prog[2] = 16'hFF06;
        prog[3] = 16'h000B; prog[4] = 16'h000B; prog[5] = 16'h00FF;
        prog[6] = 16'h000A; prog[7] = 16'h000C; prog[8] = 16'h00FF;
        prog[10] = 16'd3; prog[11] = 16'd5; prog[12] = 16'd0;
        load_and_start();
        run_steps(1, 0);
        chk("R8 upper bits ignored result", 32'(result_o), 32'd2);
        chk("R8 upper bits ignored pc", 32'(pc_o), 32'd3);
        run_steps(1, 0);
        chk("R6 zero falls through", 32'(pc_o), 32'd6);
        run_steps(1, 0);
        chk("R7 all-ones target halts", 32'(halted_o), 32'd1);
        chk("R5 negative result", 32'(result_o), 32'hFFFD);
        run_steps(3, 0);
        chk("R7 pc frozen after halt", 32'(pc_o), 32'hFF);

        // Directed: self-jump halt
        for (int i = 0; i < 256; i++) prog[i] = 16'h0;
        prog[0] = 16'd40; prog[1] = 16'd41; prog[2] = 16'd0;
        prog[40] = 16'd5; prog[41] = 16'd2;
        load_and_start();
        run_steps(4, 0);
        chk("R7 self-jump halts", 32'(halted_o), 32'd1);

        // Directed: instruction straddling 255 wraps (R3, R6)
        for (int i = 0; i < 256; i++) prog[i] = 16'h0;
        prog[0] = 16'd50; prog[1] = 16'd51; prog[2] = 16'd254;
        prog[50] = 16'd1; prog[51] = 16'd0; prog[52] = 16'd0; prog[53] = 16'd5;
        prog[254] = 16'd52; prog[255] = 16'd53;
        load_and_start();
        run_steps(1, 0);
        chk("R5 branch to 254", 32'(pc_o), 32'd254);
        run_steps(6, 0);

        // Directed: signed wrap 0x8000 - 1 is positive
        for (int i = 0; i < 256; i++) prog[i] = 16'h0;
        prog[0] = 16'd60; prog[1] = 16'd61; prog[2] = 16'd30;
        prog[60] = 16'd1; prog[61] = 16'h8000;
        load_and_start();
        run_steps(1, 0);
        chk("R3 wrap to 0x7FFF", 32'(result_o), 32'h7FFF);
        chk("R6 no branch on wrap", 32'(pc_o), 32'd3);

        // Random programs, some with load strobes during execution (R2)
        for (int t = 0; t < 20; t++) begin
            for (int i = 0; i < 256; i++) prog[i] = 16'($urandom);
            load_and_start();
            run_steps(40, (t % 2) == 1);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule